// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block fetches address translation information from memory after the translation cache reports a miss. It takes the virtual address and the table base register and forms the address of a first-level descriptor. It reads that word through a request/acknowledge memory port and decodes its two type bits.

A section descriptor ends the walk after one read. A page-table descriptor starts a second read in the table that the descriptor points to. An invalid or reserved type ends the walk with a fault.

Each walk finishes with a one-cycle completion pulse. The pulse carries either a fill record for the translation cache or a fault code, and in both cases a domain number. The fill record holds the physical base, the mapping size, the access-permission bits and the cacheable and bufferable bits. The walker then returns to idle and waits for the next miss. It does no permission checking and keeps no fault registers or cache storage.

Top module: `tt_walker`

## Requirements
- R1: After reset `mem_req_o`, `done_o` and `fault_o` are low, and the walker waits in idle.
- R2: A walk starts only when `miss_i` is high while the walker is idle. On the next cycle `mem_req_o` rises with `mem_addr_o = {ttb_i[31:14], va_i[31:20], 2'b00}`. Bits 13:0 of `ttb_i` have no effect. The virtual address and the table base are captured when the walk starts.
- R3: While `mem_req_o` is high and `mem_ack_i` is low, `mem_req_o` stays high and `mem_addr_o` does not change. Read data is taken in the cycle in which `mem_ack_i` is high.
- R4: A first-level word with bits [1:0] = 2'b10 is a section. After that single read, `done_o` pulses with `fault_o` low and `fault_code_o` = 2'b00. The fill record is:
  - `fill_base_o` = {word[31:20], 20'h0}
  - `fill_size_o` = 2'b00
  - `fill_domain_o` = word[8:5]
  - `fill_ap_o` = the 2-bit field word[11:10] repeated four times
  - `fill_c_o` = word[3] and `fill_b_o` = word[2]
- R5: A first-level word with bits [1:0] = 2'b00 or 2'b11 ends the walk after that one read. `done_o` pulses with `fault_o` high, `fault_code_o` = 2'b01 and `fill_domain_o` = word[8:5].
- R6: A first-level word with bits [1:0] = 2'b01 starts a second read at `{word[31:10], va[19:12], 2'b00}`.
- R7: A second-level word with bits [1:0] = 2'b01 is a large page. The fill record is:
  - `fill_base_o` = {word[31:16], 16'h0}
  - `fill_size_o` = 2'b01
  - `fill_ap_o` = word[11:4]
  - `fill_c_o` = word[3] and `fill_b_o` = word[2]
  - `fill_domain_o` = bits [8:5] of the first-level word
  `fault_o` is low.
- R8: A second-level word with bits [1:0] = 2'b10 is a small page. It gives the same record as R7 except that `fill_base_o` = {word[31:12], 12'h0} and `fill_size_o` = 2'b10.
- R9: A second-level word with bits [1:0] = 2'b00 or 2'b11 ends the walk with `fault_o` high, `fault_code_o` = 2'b10 and the first-level domain on `fill_domain_o`.
- R10: `done_o` is high for exactly one cycle, on the cycle after the final acknowledge. `mem_req_o` is low while `done_o` is high. `miss_i` is ignored while a walk is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_i | input | 1 | Translation cache miss; starts a walk when idle |
| va_i | input | 32 | Virtual address that missed |
| ttb_i | input | 32 | Translation table base register |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Memory read address |
| mem_ack_i | input | 1 | Memory acknowledge; read data valid |
| mem_rdata_i | input | 32 | Memory read data |
| done_o | output | 1 | One-cycle walk completion pulse |
| fault_o | output | 1 | Walk ended in a fault (valid with done_o) |
| fault_code_o | output | 2 | 00 none, 01 first-level fault, 10 second-level fault |
| fill_base_o | output | 32 | Physical base of the mapping |
| fill_size_o | output | 2 | 00 section, 01 large page, 10 small page |
| fill_domain_o | output | 4 | Domain from the first-level descriptor |
| fill_ap_o | output | 8 | Access-permission bits |
| fill_c_o | output | 1 | Cacheable bit |
| fill_b_o | output | 1 | Bufferable bit |

## Verification
Two cases are the hardest to reach from the ports. The first is a two-read walk that ends in a second-level fault: the domain must still come from the first-level word, which is no longer on the bus. The second is a new miss, or a changed virtual address, arriving while a walk is still waiting for an acknowledge.

The bench reaches them by holding off the acknowledge for a chosen number of cycles. During that wait it changes `va_i` and pulses `miss_i`. It then checks that both addresses were built from the captured values and that no extra walk follows the completion pulse.

// File: rtl/tt_walker.sv
module tt_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        miss_i,
  input  logic [31:0] va_i,
  input  logic [31:0] ttb_i,
  output logic        mem_req_o,
  output logic [31:0] mem_addr_o,
  input  logic        mem_ack_i,
  input  logic [31:0] mem_rdata_i,
  output logic        done_o,
  output logic        fault_o,
  output logic [1:0]  fault_code_o,
  output logic [31:0] fill_base_o,
  output logic [1:0]  fill_size_o,
  output logic [3:0]  fill_domain_o,
  output logic [7:0]  fill_ap_o,
  output logic        fill_c_o,
  output logic        fill_b_o
);

  typedef enum logic [1:0] {S_IDLE, S_FIRST, S_SECOND} state_t;

  state_t      st;
  logic [31:0] va_q;
  logic [17:0] base_q;
  logic [21:0] l2_tab_q;
  logic [3:0]  dom_q;

  assign mem_req_o  = (st != S_IDLE);
  assign mem_addr_o = (st == S_SECOND) ? {l2_tab_q, va_q[19:12], 2'b00}
                                       : {base_q, va_q[31:20], 2'b00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= S_IDLE;
      va_q          <= '0;
      base_q        <= '0;
      l2_tab_q      <= '0;
      dom_q         <= '0;
      done_o        <= 1'b0;
      fault_o       <= 1'b0;
      fault_code_o  <= 2'b00;
      fill_base_o   <= '0;
      fill_size_o   <= 2'b00;
      fill_domain_o <= '0;
      fill_ap_o     <= '0;
      fill_c_o      <= 1'b0;
      fill_b_o      <= 1'b0;
    end else begin
      done_o  <= 1'b0;
      fault_o <= 1'b0;
      case (st)
        S_IDLE: if (miss_i) begin
          va_q   <= va_i;
          base_q <= ttb_i[31:14];
          st     <= S_FIRST;
        end
        S_FIRST: if (mem_ack_i) begin
          dom_q         <= mem_rdata_i[8:5];
          fill_domain_o <= mem_rdata_i[8:5];
          case (mem_rdata_i[1:0])
            2'b01: begin
              l2_tab_q <= mem_rdata_i[31:10];
              st       <= S_SECOND;
            end
            2'b10: begin
              done_o       <= 1'b1;
              fault_code_o <= 2'b00;
              fill_base_o  <= {mem_rdata_i[31:20], 20'h0};
              fill_size_o  <= 2'b00;
              fill_ap_o    <= {4{mem_rdata_i[11:10]}};
              fill_c_o     <= mem_rdata_i[3];
              fill_b_o     <= mem_rdata_i[2];
              st           <= S_IDLE;
            end
            default: begin
              done_o       <= 1'b1;
              fault_o      <= 1'b1;
              fault_code_o <= 2'b01;
              st           <= S_IDLE;
            end
          endcase
        end
        S_SECOND: if (mem_ack_i) begin
          done_o        <= 1'b1;
          fill_domain_o <= dom_q;
          st            <= S_IDLE;
          case (mem_rdata_i[1:0])
            2'b01: begin
              fault_code_o <= 2'b00;
              fill_base_o  <= {mem_rdata_i[31:16], 16'h0};
              fill_size_o  <= 2'b01;
              fill_ap_o    <= mem_rdata_i[11:4];
              fill_c_o     <= mem_rdata_i[3];
              fill_b_o     <= mem_rdata_i[2];
            end
            2'b10: begin
              fault_code_o <= 2'b00;
              fill_base_o  <= {mem_rdata_i[31:12], 12'h0};
              fill_size_o  <= 2'b10;
              fill_ap_o    <= mem_rdata_i[11:4];
              fill_c_o     <= mem_rdata_i[3];
              fill_b_o     <= mem_rdata_i[2];
            end
            default: begin
              fault_o      <= 1'b1;
              fault_code_o <= 2'b10;
            end
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o))); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10
  AST_NO_REQ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !mem_req_o); // R10
  AST_FAULT_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (done_o && fault_code_o != 2'b00)); // R5
  AST_START_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req_o && !miss_i) |=> !mem_req_o); // R2
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00)); // R2

endmodule

// File: tb/tt_walker_tb_top.sv
module tt_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_i = 1'b0;
  logic [31:0] va_i = '0;
  logic [31:0] ttb_i = '0;
  logic        mem_ack_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        mem_req_o, done_o, fault_o, fill_c_o, fill_b_o;
  logic [31:0] mem_addr_o, fill_base_o;
  logic [1:0]  fault_code_o, fill_size_o;
  logic [3:0]  fill_domain_o;
  logic [7:0]  fill_ap_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  tt_walker dut_i (
    .clk(clk), .rst_n(rst_n), .miss_i(miss_i), .va_i(va_i), .ttb_i(ttb_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_ack_i(mem_ack_i),
    .mem_rdata_i(mem_rdata_i), .done_o(done_o), .fault_o(fault_o),
    .fault_code_o(fault_code_o), .fill_base_o(fill_base_o), .fill_size_o(fill_size_o),
    .fill_domain_o(fill_domain_o), .fill_ap_o(fill_ap_o), .fill_c_o(fill_c_o),
    .fill_b_o(fill_b_o)
  );

  // {va, ttb, first-level word, second-level word, ack delay}
  localparam int NV = 7;
  localparam logic [135:0] VEC [NV] = '{
    {32'h1234_5678, 32'h0004_3FFF, 32'hABC0_0D3E, 32'h0000_0000, 8'd0},
    {32'hFFF0_0000, 32'hFFFF_C000, 32'h0000_01E0, 32'h0000_0000, 8'd0},
    {32'h0010_0000, 32'h0000_0123, 32'hFFFF_FFFF, 32'h0000_0000, 8'd2},
    {32'h8765_4321, 32'h1234_4000, 32'h0012_3461, 32'h8765_4FF5, 8'd1},
    {32'h0ABC_DEF0, 32'hFFFF_FFFF, 32'h0ABC_D5E1, 32'h1357_9AB6, 8'd3},
    {32'h0000_1000, 32'h0000_8000, 32'hFFFF_FDE1, 32'h1111_1110, 8'd0},
    {32'h5555_AAAA, 32'h4444_0000, 32'h0000_0041, 32'h2222_2223, 8'd2}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic serve(input logic [31:0] exp_addr, input logic [31:0] data,
                       input int dly, input string req, input bit poke);
    chk(mem_req_o === 1'b1, req, "req raised", {31'b0, mem_req_o}, 32'h1);
    chk(mem_addr_o === exp_addr, req, "read address", mem_addr_o, exp_addr);
    for (int i = 0; i < dly; i++) begin
      if (poke) begin miss_i = 1'b1; va_i = ~va_i; end
      @(negedge clk);
      miss_i = 1'b0;
      chk(mem_req_o === 1'b1 && mem_addr_o === exp_addr, "R3", "held",
          mem_addr_o, exp_addr);
    end
    mem_ack_i = 1'b1; mem_rdata_i = data;
    @(negedge clk);
    mem_ack_i = 1'b0; mem_rdata_i = 32'hDEAD_BEEF;
  endtask

  task automatic walk(input logic [31:0] va, input logic [31:0] ttb,
                      input logic [31:0] d1, input logic [31:0] d2, input int dly,
                      input bit poke);
    logic [31:0] a1, a2;
    a1 = {ttb[31:14], va[31:20], 2'b00};
    a2 = {d1[31:10], va[19:12], 2'b00};
    @(negedge clk);
    miss_i = 1'b1; va_i = va; ttb_i = ttb;
    @(negedge clk);
    miss_i = 1'b0; va_i = ~va; ttb_i = ~ttb;
    serve(a1, d1, dly, "R2", poke);
    if (d1[1:0] == 2'b01) begin
      chk(done_o === 1'b0, "R6", "no done after page-table word", {31'b0, done_o}, 32'h0);
      serve(a2, d2, dly, "R6", poke);
      chk(done_o === 1'b1, "R10", "done after second read", {31'b0, done_o}, 32'h1);
      chk(fill_domain_o === d1[8:5], "R9", "domain from first level",
          {28'b0, fill_domain_o}, {28'b0, d1[8:5]});
      case (d2[1:0])
        2'b01: begin
          chk(fault_o === 1'b0 && fill_size_o === 2'b01, "R7", "large size",
              {30'b0, fill_size_o}, 32'h1);
          chk(fill_base_o === {d2[31:16], 16'h0}, "R7", "large base",
              fill_base_o, {d2[31:16], 16'h0});
          chk({fill_ap_o, fill_c_o, fill_b_o} === d2[11:2], "R7", "ap/cb",
              {22'b0, fill_ap_o, fill_c_o, fill_b_o}, {22'b0, d2[11:2]});
        end
        2'b10: begin
          chk(fault_o === 1'b0 && fill_size_o === 2'b10, "R8", "small size",
              {30'b0, fill_size_o}, 32'h2);
          chk(fill_base_o === {d2[31:12], 12'h0}, "R8", "small base",
              fill_base_o, {d2[31:12], 12'h0});
          chk({fill_ap_o, fill_c_o, fill_b_o} === d2[11:2], "R8", "ap/cb",
              {22'b0, fill_ap_o, fill_c_o, fill_b_o}, {22'b0, d2[11:2]});
        end
        default:
          chk(fault_o === 1'b1 && fault_code_o === 2'b10, "R9", "second-level fault",
              {30'b0, fault_code_o}, 32'h2);
      endcase
    end else begin
      chk(done_o === 1'b1, "R10", "done after one read", {31'b0, done_o}, 32'h1);
      chk(fill_domain_o === d1[8:5], "R5", "domain",
          {28'b0, fill_domain_o}, {28'b0, d1[8:5]});
      if (d1[1:0] == 2'b10) begin
        chk(fault_o === 1'b0 && fault_code_o === 2'b00 && fill_size_o === 2'b00,
            "R4", "section ok", {30'b0, fill_size_o}, 32'h0);
        chk(fill_base_o === {d1[31:20], 20'h0}, "R4", "section base",
            fill_base_o, {d1[31:20], 20'h0});
        chk(fill_ap_o === {4{d1[11:10]}} && fill_c_o === d1[3] && fill_b_o === d1[2],
            "R4", "section ap/cb", {24'b0, fill_ap_o}, {24'b0, {4{d1[11:10]}}});
      end else begin
        chk(fault_o === 1'b1 && fault_code_o === 2'b01, "R5", "first-level fault",
            {30'b0, fault_code_o}, 32'h1);
      end
    end
    chk(mem_req_o === 1'b0, "R10", "no req with done", {31'b0, mem_req_o}, 32'h0);
    @(negedge clk);
    chk(done_o === 1'b0 && mem_req_o === 1'b0, "R10", "pulse ends, idle",
        {30'b0, done_o, mem_req_o}, 32'h0);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_req_o === 1'b0 && done_o === 1'b0 && fault_o === 1'b0, "R1", "reset state",
        {29'b0, mem_req_o, done_o, fault_o}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(mem_req_o === 1'b0, "R2", "no walk without miss", {31'b0, mem_req_o}, 32'h0);

    for (int k = 0; k < NV; k++)
      walk(VEC[k][135:104], VEC[k][103:72], VEC[k][71:40], VEC[k][39:8],
           int'(VEC[k][7:0]), 1'b0);

    // R10: misses and address changes during a walk are ignored
    walk(32'h0246_8ACE, 32'h000C_0000, 32'h0F0F_0F61, 32'hF000_0AA6, 3, 1'b1);
    repeat (2) @(negedge clk);
    chk(mem_req_o === 1'b0, "R10", "no extra walk after busy miss",
        {31'b0, mem_req_o}, 32'h0);

    // R1: reset during a walk returns to idle
    @(negedge clk); miss_i = 1'b1; va_i = 32'h1; ttb_i = 32'h0;
    @(negedge clk); miss_i = 1'b0; rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk(mem_req_o === 1'b0 && done_o === 1'b0, "R1", "reset aborts walk",
        {30'b0, mem_req_o, done_o}, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule